// File: doc/BRIEF.md
# Message Descriptor Stack Writer

This block keeps a ring of message descriptors in an external word-wide RAM. Each serial-bus message gets one four-word slot. When the protocol logic signals that a message has begun, the block fills the slot: a status word carrying a start flag, the current time tag, a zero word, and a mode-dependent word. The mode-dependent word is the data block address in controller mode and the received command word in terminal mode. When the message finishes, the block rewrites the status word with an end flag, the error flag and, in terminal mode, the bus the message arrived on. It then writes a fresh time tag and moves its stack pointer to the next slot.

The ring holds 64 slots and wraps from the last slot back to the first. The host must load the pointer before traffic starts. RAM writes leave through a one-word-per-clock write port. A busy output covers each write burst, and strobes that arrive during a burst are not accepted.

Top module: `desc_stack_writer`

## Requirements
- R1: After reset, busy is 0, ram_we is 0 and stack_ptr is 0.
- R2: An accepted start strobe writes four words on consecutive cycles. The first write appears two cycles after the strobe is sampled. Offset 0 gets a status word with only bit 15 set. Offset 1 gets time_now as sampled with the strobe. Offset 2 gets zero.
- R3: The word at offset 3 is blk_addr when ctl_mode is 1 (controller) and cmd_word when ctl_mode is 0 (terminal). Both are sampled with the start strobe.
- R4: An accepted end strobe writes two words. Offset 0 gets a status word with bit 14 set as the end flag. Bit 12 is msg_err. Bit 13 is bus_b when ctl_mode is 0 and is 0 when ctl_mode is 1. All other bits are 0. Offset 1 gets time_now as sampled with the end strobe.
- R5: After an accepted end, stack_ptr advances by 4. From 252 it wraps to 0.
- R6: An end strobe while no message is open writes nothing and leaves stack_ptr unchanged.
- R7: busy rises the cycle after a strobe is accepted. It stays high until the cycle after the last word is written. Start, end and load strobes seen while busy is high are ignored.
- R8: A load while idle sets stack_ptr to ptr_load_val with its two low bits cleared. It also closes any open message. Start and end strobes in the same cycle are ignored.
- R9: A second start while a message is open rewrites the same slot, and stack_ptr is unchanged.
- R10: When start and end are sampled together, the start is taken and the end is dropped.
- R11: Every write goes to RAM address BASE + stack_ptr + word offset (0 to 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_load | input | 1 | Host pointer load strobe |
| ptr_load_val | input | PW (8) | Word offset to load into the pointer |
| msg_start | input | 1 | Message start strobe |
| msg_end | input | 1 | Message end strobe |
| ctl_mode | input | 1 | 1 = controller mode, 0 = terminal mode |
| bus_b | input | 1 | 1 = message on bus B, 0 = bus A |
| msg_err | input | 1 | Error found in the message |
| blk_addr | input | DW (16) | Message data block address (controller mode) |
| cmd_word | input | DW (16) | Received command word (terminal mode) |
| time_now | input | DW (16) | Free-running time counter |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW (12) | RAM write address |
| ram_wdata | output | DW (16) | RAM write data |
| busy | output | 1 | Write burst in progress |
| stack_ptr | output | PW (8) | Word offset of the current slot in the ring |

## Verification
If the internal open-message flag is wrong, the error shows on the first end strobe. The block either writes two words it should not write, or skips them, and stack_ptr then differs by 4 from the expected value. A wrong word counter or state register shows within one burst as a missing, extra or shifted write, or as busy falling out of step with ram_we. A pointer step or wrap error appears on ram_addr at the next start strobe, which the bench checks against a pointer it models itself.

// File: rtl/dsw_pkg.sv
`timescale 1ns/100ps
package dsw_pkg;
  localparam int SOM_BIT  = 15;
  localparam int EOM_BIT  = 14;
  localparam int BUSB_BIT = 13;
  localparam int ERR_BIT  = 12;
  localparam int END_WORDS = 2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_OPEN, SQ_CLOSE} seq_e;
endpackage

// File: rtl/dsw_status_fmt.sv
`timescale 1ns/100ps
module dsw_status_fmt #(
  parameter int DW = 16
) (
  input  logic          ctl_mode,
  input  logic          bus_b,
  input  logic          msg_err,
  output logic [DW-1:0] som_word,
  output logic [DW-1:0] eom_word
);
  import dsw_pkg::*;

  always_comb begin
    som_word = '0;
    som_word[SOM_BIT] = 1'b1;
    eom_word = '0;
    eom_word[EOM_BIT]  = 1'b1;
    eom_word[BUSB_BIT] = bus_b & ~ctl_mode;
    eom_word[ERR_BIT]  = msg_err;
  end
endmodule

// File: rtl/dsw_ptr.sv
`timescale 1ns/100ps
module dsw_ptr #(
  parameter int PW  = 8,
  parameter int WPE = 4,
  localparam int CW = $clog2(WPE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (load)
      ptr <= {load_val[PW-1:CW], {CW{1'b0}}};
    else if (adv)
      ptr <= ptr + PW'(WPE);
  end
endmodule

// File: rtl/dsw_seq.sv
`timescale 1ns/100ps
module dsw_seq #(
  parameter int DW   = 16,
  parameter int AW   = 12,
  parameter int PW   = 8,
  parameter int WPE  = 4,
  parameter logic [AW-1:0] BASE = '0,
  localparam int CW = $clog2(WPE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          msg_start,
  input  logic          msg_end,
  input  logic          ptr_load,
  input  logic          ctl_mode,
  input  logic [DW-1:0] blk_addr,
  input  logic [DW-1:0] cmd_word,
  input  logic [DW-1:0] time_now,
  input  logic [DW-1:0] som_word,
  input  logic [DW-1:0] eom_word,
  input  logic [PW-1:0] ptr,
  output logic          load_ok,
  output logic          adv,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          busy
);
  import dsw_pkg::*;

  seq_e          st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_idx;
  logic          open_q;
  logic [DW-1:0] w0_q, w1_q, w3_q;
  logic [DW-1:0] word_sel;
  logic [AW-1:0] addr_nxt;
  logic          idle_ok, open_ok, close_ok;

  assign idle_ok  = (st_q == SQ_IDLE) && !busy;
  assign load_ok  = idle_ok && ptr_load;
  assign open_ok  = idle_ok && !ptr_load && msg_start;
  assign close_ok = idle_ok && !ptr_load && !msg_start && msg_end && open_q;

  assign last_idx = (st_q == SQ_OPEN) ? CW'(WPE - 1) : CW'(END_WORDS - 1);
  assign adv      = (st_q == SQ_CLOSE) && (cnt_q == last_idx);
  assign addr_nxt = BASE + {{(AW-PW){1'b0}}, ptr} + {{(AW-CW){1'b0}}, cnt_q};

  always_comb begin
    case (cnt_q)
      CW'(0):  word_sel = w0_q;
      CW'(1):  word_sel = w1_q;
      CW'(2):  word_sel = '0;
      default: word_sel = w3_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SQ_IDLE;
      cnt_q     <= '0;
      open_q    <= 1'b0;
      busy      <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      w0_q      <= '0;
      w1_q      <= '0;
      w3_q      <= '0;
    end else begin
      ram_we <= 1'b0;
      if (st_q == SQ_IDLE) begin
        busy  <= 1'b0;
        cnt_q <= '0;
        if (load_ok) begin
          open_q <= 1'b0;
        end else if (open_ok) begin
          st_q   <= SQ_OPEN;
          busy   <= 1'b1;
          open_q <= 1'b1;
          w0_q   <= som_word;
          w1_q   <= time_now;
          w3_q   <= ctl_mode ? blk_addr : cmd_word;
        end else if (close_ok) begin
          st_q   <= SQ_CLOSE;
          busy   <= 1'b1;
          open_q <= 1'b0;
          w0_q   <= eom_word;
          w1_q   <= time_now;
        end
      end else begin
        busy      <= 1'b1;
        ram_we    <= 1'b1;
        ram_addr  <= addr_nxt;
        ram_wdata <= word_sel;
        if (cnt_q == last_idx)
          st_q <= SQ_IDLE;
        else
          cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/desc_stack_writer.sv
`timescale 1ns/100ps
module desc_stack_writer #(
  parameter int DW      = 16,
  parameter int AW      = 12,
  parameter int ENTRIES = 64,
  parameter int WPE     = 4,
  parameter logic [AW-1:0] BASE = 12'h300,
  localparam int PW = $clog2(ENTRIES * WPE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_load,
  input  logic [PW-1:0] ptr_load_val,
  input  logic          msg_start,
  input  logic          msg_end,
  input  logic          ctl_mode,
  input  logic          bus_b,
  input  logic          msg_err,
  input  logic [DW-1:0] blk_addr,
  input  logic [DW-1:0] cmd_word,
  input  logic [DW-1:0] time_now,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          busy,
  output logic [PW-1:0] stack_ptr
);
  logic [DW-1:0] som_word, eom_word;
  logic          load_ok, adv;

  dsw_status_fmt #(.DW(DW)) u_fmt (
    .ctl_mode (ctl_mode),
    .bus_b    (bus_b),
    .msg_err  (msg_err),
    .som_word (som_word),
    .eom_word (eom_word)
  );

  dsw_ptr #(.PW(PW), .WPE(WPE)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (load_ok),
    .load_val (ptr_load_val),
    .adv      (adv),
    .ptr      (stack_ptr)
  );

  dsw_seq #(.DW(DW), .AW(AW), .PW(PW), .WPE(WPE), .BASE(BASE)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .msg_start (msg_start),
    .msg_end   (msg_end),
    .ptr_load  (ptr_load),
    .ctl_mode  (ctl_mode),
    .blk_addr  (blk_addr),
    .cmd_word  (cmd_word),
    .time_now  (time_now),
    .som_word  (som_word),
    .eom_word  (eom_word),
    .ptr       (stack_ptr),
    .load_ok   (load_ok),
    .adv       (adv),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .busy      (busy)
  );
endmodule

// File: rtl/dsw_checker.sv
`timescale 1ns/100ps
module dsw_checker #(
  parameter int DW   = 16,
  parameter int AW   = 12,
  parameter int PW   = 8,
  parameter int RING = 256,
  parameter logic [AW-1:0] BASE = '0
) (
  input logic          clk,
  input logic          rst,
  input logic          ptr_load,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic [DW-1:0] ram_wdata,
  input logic          busy,
  input logic [PW-1:0] stack_ptr
);
  logic [AW-1:0] ring_off;
  assign ring_off = ram_addr - BASE;

  a_r7_we_inside_busy: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy);

  a_r7_busy_ends_with_burst: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we) |-> !busy);

  a_r8_ptr_aligned: assert property (@(posedge clk) disable iff (rst)
    stack_ptr[1:0] == 2'b00);

  a_r5_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (stack_ptr != $past(stack_ptr)) && !$past(ptr_load)
      |-> stack_ptr == $past(stack_ptr) + PW'(4));

  a_r2_status_shape: assert property (@(posedge clk) disable iff (rst)
    ram_we && (ring_off[1:0] == 2'd0)
      |-> ($countones(ram_wdata[DW-1:DW-2]) == 1) && (ram_wdata[11:0] == '0));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ram_we && (ring_off[1:0] == 2'd2) |-> ram_wdata == '0);

  a_r11_inside_ring: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ring_off < AW'(RING));
endmodule

bind desc_stack_writer dsw_checker #(
  .DW(DW), .AW(AW), .PW(PW), .RING(ENTRIES * WPE), .BASE(BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ptr_load  (ptr_load),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .ram_wdata (ram_wdata),
  .busy      (busy),
  .stack_ptr (stack_ptr)
);

// File: tb/test_desc_stack_writer.sv
`timescale 1ns/100ps
module test_desc_stack_writer;
  localparam logic [11:0] BASE = 12'h300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ptr_load = 1'b0;
  logic [7:0]  ptr_load_val = '0;
  logic        msg_start = 1'b0, msg_end = 1'b0;
  logic        ctl_mode = 1'b0, bus_b = 1'b0, msg_err = 1'b0;
  logic [15:0] blk_addr = '0, cmd_word = '0, time_now = '0;
  logic        ram_we, busy;
  logic [11:0] ram_addr;
  logic [15:0] ram_wdata;
  logic [7:0]  stack_ptr;

  always #2.5 clk = ~clk;

  desc_stack_writer i_desc_stack_writer (
    .clk(clk), .rst(rst), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
    .msg_start(msg_start), .msg_end(msg_end), .ctl_mode(ctl_mode),
    .bus_b(bus_b), .msg_err(msg_err), .blk_addr(blk_addr),
    .cmd_word(cmd_word), .time_now(time_now), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .busy(busy),
    .stack_ptr(stack_ptr)
  );

  int tests = 0, fails = 0, cyc = 0, lg_n = 0;
  bit done = 1'b0;
  logic [11:0] lg_addr [256];
  logic [15:0] lg_data [256];
  int          lg_cyc  [256];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (ram_we && lg_n < 256) begin
      lg_addr[lg_n] = ram_addr;
      lg_data[lg_n] = ram_wdata;
      lg_cyc[lg_n]  = cyc;
      lg_n = lg_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // bench model of the slot pointer and open-message flag
  logic [7:0] mp = '0;
  bit         mo = 1'b0;

  // op bits: [0] start, [1] end, [2] load. poke drives end+load during the burst.
  task automatic do_op(input logic [2:0] op, input logic mode, bus, err,
                       input logic [15:0] data, tm, input bit poke);
    int c0, b0, enw;
    logic [15:0] ed [4];
    logic [11:0] pb;
    @(negedge clk);
    msg_start = op[0]; msg_end = op[1]; ptr_load = op[2];
    ptr_load_val = data[7:0]; ctl_mode = mode; bus_b = bus; msg_err = err;
    blk_addr = data; cmd_word = ~data; time_now = tm;
    c0 = cyc; b0 = lg_n; pb = BASE + {4'h0, mp};
    enw = 0;
    if (op[2]) begin
      mp = {data[7:2], 2'b00}; mo = 1'b0;
    end else if (op[0]) begin
      enw = 4; mo = 1'b1;
      ed[0] = 16'h8000; ed[1] = tm; ed[2] = 16'h0000; ed[3] = mode ? data : ~data;
    end else if (op[1] && mo) begin
      enw = 2; mo = 1'b0; mp = mp + 8'd4;
      ed[0] = 16'h4000 | ({15'd0, bus & ~mode} << 13) | ({15'd0, err} << 12);
      ed[1] = tm;
    end
    @(negedge clk);
    msg_start = 1'b0; msg_end = 1'b0; ptr_load = 1'b0;
    if (enw > 0) check(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    if (poke) begin
      msg_end = 1'b1; ptr_load = 1'b1; ptr_load_val = 8'h80; msg_start = 1'b1;
      @(negedge clk);
      msg_end = 1'b0; ptr_load = 1'b0; msg_start = 1'b0;
    end
    for (int i = 0; i < 12 && busy; i++) @(negedge clk);
    check(busy == 1'b0, "R7 busy released", int'(busy), 0);
    check(lg_n - b0 == enw, op[1] && !op[0] ? "R6 end write count" : "R2 write count",
          lg_n - b0, enw);
    for (int i = 0; i < enw && i < lg_n - b0; i++) begin
      check(lg_addr[b0+i] == pb + 12'(i), "R11 write address", int'(lg_addr[b0+i]), int'(pb) + i);
      check(lg_data[b0+i] == ed[i], i == 3 ? "R3 mode word" : (enw == 2 ? "R4 end word" : "R2 start word"),
            int'(lg_data[b0+i]), int'(ed[i]));
      check(lg_cyc[b0+i] == c0 + 2 + i, "R2 write timing", lg_cyc[b0+i], c0 + 2 + i);
    end
    check(stack_ptr == mp, "R5 pointer", int'(stack_ptr), int'(mp));
  endtask

  // {op[3], mode, bus, err, data[16], time[16], exp_writes[3], exp_ptr[8]}
  localparam int NV = 12;
  localparam logic [48:0] VEC [NV] = '{
    {3'b100, 3'b000, 16'h000B, 16'h0000, 3'd0, 8'd8},    // R8 load, low bits cleared
    {3'b010, 3'b000, 16'h0000, 16'h0000, 3'd0, 8'd8},    // R6 end with nothing open
    {3'b001, 3'b100, 16'h1234, 16'h0100, 3'd4, 8'd8},    // R2/R3 controller start
    {3'b010, 3'b111, 16'h0000, 16'h0111, 3'd2, 8'd12},   // R4 controller end, bus bit masked
    {3'b001, 3'b000, 16'hA5C3, 16'h0200, 3'd4, 8'd12},   // R3 terminal start
    {3'b010, 3'b010, 16'h0000, 16'h0222, 3'd2, 8'd16},   // R4 terminal end on bus B
    {3'b001, 3'b000, 16'h0F0F, 16'h0300, 3'd4, 8'd16},
    {3'b001, 3'b000, 16'h7777, 16'h0301, 3'd4, 8'd16},   // R9 restart same slot
    {3'b010, 3'b001, 16'h0000, 16'h0333, 3'd2, 8'd20},   // R4 error flag
    {3'b100, 3'b000, 16'h00FE, 16'h0000, 3'd0, 8'd252},  // R8 load last slot
    {3'b001, 3'b100, 16'hBEEF, 16'h0400, 3'd4, 8'd252},
    {3'b010, 3'b110, 16'h0000, 16'h0444, 3'd2, 8'd0}     // R5 wrap to first slot
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(ram_we == 1'b0, "R1 we after reset", int'(ram_we), 0);
    check(stack_ptr == 8'd0, "R1 pointer after reset", int'(stack_ptr), 0);

    for (int v = 0; v < NV; v++) begin
      int b0;
      b0 = lg_n;
      do_op(VEC[v][48:46], VEC[v][45], VEC[v][44], VEC[v][43],
            VEC[v][42:27], VEC[v][26:11], 1'b0);
      check(lg_n - b0 == int'(VEC[v][10:8]), "R2 table write count", lg_n - b0, int'(VEC[v][10:8]));
      check(stack_ptr == VEC[v][7:0], "R5 table pointer", int'(stack_ptr), int'(VEC[v][7:0]));
    end

    // R7: strobes during a burst are dropped; message stays open
    do_op(3'b001, 1'b0, 1'b0, 1'b0, 16'h1111, 16'h0500, 1'b1);
    check(stack_ptr == 8'd0, "R7 load during busy ignored", int'(stack_ptr), 0);
    do_op(3'b010, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0501, 1'b0);
    check(stack_ptr == 8'd4, "R7 message still open", int'(stack_ptr), 4);

    // R10: start and end together -> start only
    do_op(3'b011, 1'b1, 1'b0, 1'b0, 16'h2222, 16'h0600, 1'b0);
    check(stack_ptr == 8'd4, "R10 end dropped", int'(stack_ptr), 4);
    do_op(3'b010, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0601, 1'b0);
    check(stack_ptr == 8'd8, "R10 start was open", int'(stack_ptr), 8);

    // R8: load closes an open message, and strobes beside it are ignored
    do_op(3'b001, 1'b0, 1'b0, 1'b0, 16'h3333, 16'h0700, 1'b0);
    do_op(3'b111, 1'b0, 1'b0, 1'b0, 16'h0041, 16'h0701, 1'b0);
    check(stack_ptr == 8'h40, "R8 load value", int'(stack_ptr), 'h40);
    do_op(3'b010, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h0702, 1'b0);
    check(stack_ptr == 8'h40, "R8 load closed message", int'(stack_ptr), 'h40);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule